// File: doc/BRIEF.md
# Three-Channel UART Bridge on a Shared SPI Slave

This block lets a host processor reach three independent serial ports over one SPI bus with a single chip select. The bus runs in mode 0. Each chip-select window is one transaction. A 16-bit transaction is a command to the channel that is currently chosen. An 8-bit transaction changes which channel is chosen. The choice is kept until another valid 8-bit transaction arrives, so a host that talks to one port only never has to send it.

Every channel has a programmable bit time, a transmitter with a single holding register in front of its shift register, and a receiver feeding a small FIFO. Each transmitter also drives a direction line for an RS-485 half-duplex transceiver. The line is high for exactly the duration of each outgoing character, so software does not need to turn the bus around.

The SPI inputs are brought into the system clock through synchronizers. For that reason the system clock must be at least eight times faster than SCLK.

Top module: `spi_multi_uart`

## Requirements
- R1: A 16-bit transaction is a command, shifted MSB first, with data sampled on the rising SCLK edge. Bits 15:14 select the operation: 2'b11 writes the config, 2'b01 reads the config, 2'b10 writes a transmit byte taken from bits 7:0, and 2'b00 reads a received byte.
- R2: The 16-bit reply carries the chosen channel's state at the falling edge of chip select. Bit 15 is receive-data-ready and bit 14 is transmit-holding-empty. For config commands, bits 13:0 return the stored config from before any write in the same transaction. For data commands, bits 13:8 are zero and bits 7:0 hold the oldest received byte.
- R3: An 8-bit transaction with a value from 0 to 2 chooses that channel for all later commands. Reset chooses channel 0.
- R4: An 8-bit transaction with a value of 3 or more leaves the current choice unchanged.
- R5: A transaction of any length other than 8 or 16 SCLK edges has no effect on the choice, the config, or the data.
- R6: Each channel keeps its own 14-bit config. Bits 11:0 are a divisor D, and one bit lasts D+1 system clocks. The value after reset is 15.
- R7: A written byte is sent as one low start bit, then eight data bits LSB first, then one high stop bit. The line idles high.
- R8: A channel's transmit-enable is high for exactly 10*(D+1) clocks per character, from the start bit until the stop bit ends. While it is low the line is high. The other channels' enables are not affected.
- R9: One byte may wait in the holding register while another is shifting. A data write that arrives while the holding register is full is dropped. Bit 14 of the reply reads 0 while the register is full.
- R10: Received 8N1 characters go into a 4-entry FIFO per channel. A read-data command removes one entry only if bit 15 of its reply was 1. Characters that arrive while the FIFO is full are dropped.
- R11: After reset, every serial output is high, every transmit-enable is low, and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the host, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| uart_rx | input | 3 | Serial receive line per channel |
| uart_tx | output | 3 | Serial transmit line per channel |
| uart_txen | output | 3 | RS-485 driver enable per channel |

## Verification
A corrupted channel-select register shows up on the very next command. The config read comes back with another channel's divisor, or the transmitted character appears on the wrong pin. A fault in the length counter makes an off-length transaction change the config, which the following read-back exposes. A holding register or FIFO pointer that goes wrong shows within one character time: a frame is missing or repeated on the serial pin, a transmit-enable pulse differs from 10*(D+1) clocks, or the ready flag and data byte returned by the next read-data are wrong.

// File: rtl/spi_mu_pkg.sv
// Shared definitions for the SPI multi-UART bridge.
package spi_mu_pkg;
    localparam int WORD_W = 16;  // command word length
    localparam int SEL_LEN = 8;  // channel-select transaction length
    localparam int CFG_W  = 14;  // stored config width
    localparam int DIV_W  = 12;  // divisor field inside the config
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CMD_RD_DATA = 2'b00,
        CMD_RD_CFG  = 2'b01,
        CMD_WR_DATA = 2'b10,
        CMD_WR_CFG  = 2'b11
    } cmd_e;
endpackage

// File: rtl/spi_mu_slave.sv
// SPI mode-0 slave front end. Synchronizes SCLK, CS_n and MOSI into clk.
// Counts rising SCLK edges per chip-select window and shifts MOSI in.
// Presents resp MSB first on MISO. Reports the window start, the end
// (with its length and the last WORD_W bits) and the second bit.
// Assumes clk is at least 8x SCLK.
module spi_mu_slave #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [WORD_W-1:0] resp,
    output logic              miso,
    output logic              start,
    output logic              done,
    output logic              hdr,
    output logic              hdr_bit,
    output logic [CNT_W-1:0]  len,
    output logic [WORD_W-1:0] word
);
    localparam int IDX_W = $clog2(WORD_W);

    logic [2:0] sclk_q, cs_q;
    logic [1:0] mosi_q;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic active, rise;

    // Synchronize the SPI pins and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            cs_q   <= {cs_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    assign active  = ~cs_q[1];
    assign rise    = sclk_q[1] & ~sclk_q[2];
    assign start   = cs_q[2] & ~cs_q[1];
    assign done    = ~cs_q[2] & cs_q[1];
    assign hdr     = active && rise && (cnt == CNT_W'(1));
    assign hdr_bit = mosi_q[1];
    assign len     = cnt;
    assign idx     = IDX_W'(WORD_W - 1) - cnt[IDX_W-1:0];

    // Count edges (saturating) and shift in data while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            word <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (active && rise) begin
            word <= {word[WORD_W-2:0], mosi_q[1]};
            if (cnt != '1) cnt <= cnt + 1'b1;
        end
    end

    // Drive the reply bit for the next edge; quiet outside a word.
    always_ff @(posedge clk) begin
        if (!rst_n) miso <= 1'b0;
        else if (!active || cnt >= CNT_W'(WORD_W)) miso <= 1'b0;
        else miso <= resp[idx];
    end
endmodule

// File: rtl/spi_mu_fifo.sv
// Small synchronous FIFO for received bytes. Writes to a full FIFO and
// reads from an empty one are ignored. Head data is visible without a read.
module spi_mu_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign not_empty = (wp != rp);
    assign full      = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign head      = mem[rp[AW-1:0]];

    // Advance pointers; storage has no reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && not_empty) rp <= rp + 1'b1;
        end
    end

    // Write storage.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wp[AW-1:0]] <= din;
    end
endmodule

// File: rtl/spi_mu_chan.sv
// One UART channel: config register, 8N1 transmitter with a one-byte
// holding register and a direction output, and an 8N1 receiver into a FIFO.
// The bit time is cfg[DIV_W-1:0]+1 clocks. Assumes rx is asynchronous.
module spi_mu_chan #(
    parameter int CFG_W   = 14,
    parameter int DIV_W   = 12,
    parameter int DEPTH   = 4,
    parameter int DEF_DIV = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic             tx_wr,
    input  logic [7:0]       tx_byte,
    input  logic             rx_pop,
    input  logic             rx,
    output logic [CFG_W-1:0] cfg,
    output logic             tx_empty,
    output logic             rx_rdy,
    output logic [7:0]       rx_byte,
    output logic             tx,
    output logic             tx_en
);
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

    logic [DIV_W-1:0] div, tcnt, rcnt;
    logic [7:0] hold, rsh;
    logic       hold_v, busy, rx_push, rx_full;
    logic [9:0] tsh;
    logic [3:0] tidx;
    logic [2:0] ridx;
    logic [1:0] rx_q;
    rx_st_e     rst_q;

    assign div      = cfg[DIV_W-1:0];
    assign tx_empty = ~hold_v;
    assign tx       = busy ? tsh[0] : 1'b1;
    assign tx_en    = busy;

    // Config register, written by the bridge.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg <= CFG_W'(DEF_DIV);
        else if (cfg_we) cfg <= cfg_in;
    end

    // Holding register and transmit shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold   <= '0;
            busy   <= 1'b0;
            tsh    <= '1;
            tcnt   <= '0;
            tidx   <= '0;
        end else begin
            if (tx_wr && !hold_v) begin
                hold   <= tx_byte;
                hold_v <= 1'b1;
            end
            if (!busy && hold_v) begin
                tsh    <= {1'b1, hold, 1'b0};
                busy   <= 1'b1;
                tcnt   <= div;
                tidx   <= '0;
                hold_v <= 1'b0;
            end else if (busy) begin
                if (tcnt == '0) begin
                    tcnt <= div;
                    if (tidx == 4'd9) busy <= 1'b0;
                    else begin
                        tsh  <= {1'b1, tsh[9:1]};
                        tidx <= tidx + 1'b1;
                    end
                end else tcnt <= tcnt - 1'b1;
            end
        end
    end

    // Receive line synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '1;
        else rx_q <= {rx_q[0], rx};
    end

    // Receiver: find the start bit, sample each bit mid-cell, check the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q   <= RX_IDLE;
            rcnt    <= '0;
            ridx    <= '0;
            rsh     <= '0;
            rx_push <= 1'b0;
        end else begin
            rx_push <= 1'b0;
            case (rst_q)
                RX_IDLE: if (!rx_q[1]) begin
                    rst_q <= RX_START;
                    rcnt  <= div >> 1;
                end
                RX_START: if (rcnt == '0) begin
                    rst_q <= rx_q[1] ? RX_IDLE : RX_DATA;
                    rcnt  <= div;
                    ridx  <= '0;
                end else rcnt <= rcnt - 1'b1;
                RX_DATA: if (rcnt == '0) begin
                    rsh  <= {rx_q[1], rsh[7:1]};
                    rcnt <= div;
                    if (ridx == 3'd7) rst_q <= RX_STOP;
                    else ridx <= ridx + 1'b1;
                end else rcnt <= rcnt - 1'b1;
                default: if (rcnt == '0) begin
                    rx_push <= rx_q[1] & ~rx_full;
                    rst_q   <= RX_IDLE;
                end else rcnt <= rcnt - 1'b1;
            endcase
        end
    end

    spi_mu_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rsh), .pop(rx_pop),
        .head(rx_byte), .not_empty(rx_rdy), .full(rx_full)
    );
endmodule

// File: rtl/spi_multi_uart.sv
// Top of the SPI-to-three-UART bridge. Decodes transaction length: 8 edges
// select a channel, 16 edges run a command on the selected channel, and any
// other length is discarded. Builds the reply from the selected channel.
module spi_multi_uart
    import spi_mu_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int DEPTH   = 4,
    parameter int DEF_DIV = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           spi_sclk,
    input  logic           spi_cs_n,
    input  logic           spi_mosi,
    output logic           spi_miso,
    input  logic [NCH-1:0] uart_rx,
    output logic [NCH-1:0] uart_tx,
    output logic [NCH-1:0] uart_txen
);
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CNT_W = $clog2(WORD_W) + 1;

    logic              start, done, hdr, hdr_bit;
    logic [CNT_W-1:0]  len;
    logic [WORD_W-1:0] word, resp;
    logic [SEL_W-1:0]  sel_q;
    logic [NCH-1:0]    cfg_we, tx_wr, pop, rdy, empty;
    logic [CFG_W-1:0]  cfg [NCH];
    logic [7:0]        rxb [NCH];
    cmd_e              cmd;

    assign cmd = cmd_e'(word[WORD_W-1 -: 2]);

    spi_mu_slave #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_slave (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .resp(resp), .miso(spi_miso), .start(start),
        .done(done), .hdr(hdr), .hdr_bit(hdr_bit), .len(len), .word(word)
    );

    // Channel choice: only an 8-edge transaction with an in-range value moves it.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else if (done && len == CNT_W'(SEL_LEN) && int'(word[7:0]) < NCH)
            sel_q <= word[SEL_W-1:0];
    end

    // Reply: status snapshot at window start, config swapped in after bit 14.
    always_ff @(posedge clk) begin
        if (!rst_n) resp <= '0;
        else if (start) resp <= {rdy[sel_q], empty[sel_q], 6'b0, rxb[sel_q]};
        else if (hdr && hdr_bit) resp[CFG_W-1:0] <= cfg[sel_q];
    end

    // Per-channel strobes at the end of a full command word.
    always_comb begin
        cfg_we = '0;
        tx_wr  = '0;
        pop    = '0;
        if (done && len == CNT_W'(WORD_W)) begin
            case (cmd)
                CMD_WR_CFG:  cfg_we[sel_q] = 1'b1;
                CMD_WR_DATA: tx_wr[sel_q]  = 1'b1;
                CMD_RD_DATA: pop[sel_q]    = resp[WORD_W-1];
                default: ;
            endcase
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        spi_mu_chan #(.CFG_W(CFG_W), .DIV_W(DIV_W), .DEPTH(DEPTH),
                      .DEF_DIV(DEF_DIV)) u_ch (
            .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[c]),
            .cfg_in(word[CFG_W-1:0]), .tx_wr(tx_wr[c]), .tx_byte(word[7:0]),
            .rx_pop(pop[c]), .rx(uart_rx[c]), .cfg(cfg[c]),
            .tx_empty(empty[c]), .rx_rdy(rdy[c]), .rx_byte(rxb[c]),
            .tx(uart_tx[c]), .tx_en(uart_txen[c])
        );
    end
endmodule

// File: rtl/spi_mu_chk.sv
// Property checker for spi_multi_uart, attached by bind below.
module spi_mu_chk #(
    parameter int NCH   = 3,
    parameter int SEL_W = 2,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] sel_q,
    input logic             done,
    input logic [CNT_W-1:0] len,
    input logic [NCH-1:0]   uart_tx,
    input logic [NCH-1:0]   uart_txen,
    input logic [NCH-1:0]   pop,
    input logic [NCH-1:0]   rdy
);
    // R4: the choice never points past the last channel.
    a_r4_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_q) < NCH);

    // R3: the choice moves only at the end of an 8-edge transaction.
    a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && len == CNT_W'(8)) |=> $stable(sel_q));

    for (genvar c = 0; c < NCH; c++) begin : g_a
        // R8: with the driver disabled the line idles high.
        a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
            !uart_txen[c] |-> uart_tx[c]);
        // R7: an enable pulse opens with the start bit.
        a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(uart_txen[c]) |-> !uart_tx[c]);
        // R10: a read never removes from an empty FIFO.
        a_r10_pop_ready: assert property (@(posedge clk) disable iff (!rst_n)
            pop[c] |-> rdy[c]);
    end
endmodule

bind spi_multi_uart spi_mu_chk #(.NCH(NCH), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .done(done), .len(len),
    .uart_tx(uart_tx), .uart_txen(uart_txen), .pop(pop), .rdy(rdy)
);

// File: tb/spi_multi_uart_test.sv
// Directed bench for spi_multi_uart: one task per scenario.
module spi_multi_uart_test;
    localparam int HP = 8;  // SCLK half period in clk cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [2:0] urx = 3'b111;
    logic [2:0] utx, uten;

    int checks = 0, errors = 0;
    int bt [3] = '{16, 16, 16};
    logic [7:0] got [3][8];
    int ngot [3] = '{0, 0, 0};
    bit finished = 0;

    always #2 clk = ~clk;

    spi_multi_uart uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .uart_rx(urx), .uart_tx(utx),
        .uart_txen(uten)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input int nbits, input logic [31:0] din, output logic [15:0] dout);
        dout = '0;
        cs_n = 1'b0;
        repeat (2 * HP) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = din[i];
            repeat (HP) @(negedge clk);
            dout = {dout[14:0], miso};
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HP) @(negedge clk);
    endtask

    task automatic pick(input int ch);
        logic [15:0] d;
        xfer(8, ch, d);
    endtask

    task automatic cmd(input logic [15:0] w, output logic [15:0] r);
        xfer(16, {16'b0, w}, r);
    endtask

    // Decodes every frame on one channel's serial output.
    task automatic mon(input int ch);
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (utx[ch] === 1'b0) begin
                repeat (bt[ch] / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (bt[ch]) @(negedge clk);
                    b[i] = utx[ch];
                end
                repeat (bt[ch]) @(negedge clk);
                chk(utx[ch] === 1'b1, "R7 stop bit", utx[ch], 1);
                if (ngot[ch] < 8) got[ch][ngot[ch]] = b;
                ngot[ch]++;
            end
        end
    endtask

    task automatic send_rx(input int ch, input logic [7:0] b);
        logic [9:0] f;
        f = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            urx[ch] = f[i];
            repeat (bt[ch]) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [15:0] r;
        chk(utx === 3'b111, "R11 tx idle", utx, 7);
        chk(uten === 3'b000, "R11 txen low", uten, 0);
        chk(miso === 1'b0, "R11 miso low", miso, 0);
        cmd(16'h4000, r);
        chk(r === 16'h400F, "R6 default config and R2 status", r, 16'h400F);
    endtask

    task automatic t_tx_basic;
        logic [15:0] r;
        int hi = 0;
        bit other = 0;
        pick(2);
        fork
            begin
                while (uten[2] !== 1'b1) @(negedge clk);
                while (uten[2] === 1'b1) begin
                    hi++;
                    if (uten[1:0] != 2'b00) other = 1;
                    @(negedge clk);
                end
            end
        join_none
        cmd(16'h80A5, r);
        repeat (300) @(negedge clk);
        chk(hi == 160, "R8 txen width", hi, 160);
        chk(!other, "R8 other enables low", other, 0);
        chk(ngot[2] == 1 && got[2][0] == 8'hA5, "R1 R7 byte on ch2", got[2][0], 8'hA5);
        chk(ngot[0] == 0 && ngot[1] == 0, "R3 no frame elsewhere", ngot[0] + ngot[1], 0);
    endtask

    task automatic t_select;
        logic [15:0] r;
        cmd(16'hC014, r);          // ch2 divisor 20
        bt[2] = 21;
        cmd(16'h4000, r);
        chk(r[13:0] == 14'h14, "R6 config readback ch2", r[13:0], 'h14);
        pick(7);
        cmd(16'h4000, r);
        chk(r[13:0] == 14'h14, "R4 select 7 ignored", r[13:0], 'h14);
        pick(3);
        cmd(16'h4000, r);
        chk(r[13:0] == 14'h14, "R4 select 3 ignored", r[13:0], 'h14);
        pick(0);
        cmd(16'h4000, r);
        chk(r[13:0] == 14'hF, "R3 ch0 config untouched", r[13:0], 'hF);
    endtask

    task automatic t_bad_len;
        logic [15:0] r;
        xfer(24, 32'h00C033, r);   // last 16 bits look like a config write
        cmd(16'h4000, r);
        chk(r[13:0] == 14'hF, "R5 24-edge ignored", r[13:0], 'hF);
        xfer(9, 32'h002, r);       // looks like select 2 but 9 edges
        cmd(16'h4000, r);
        chk(r[13:0] == 14'hF, "R5 9-edge ignored", r[13:0], 'hF);
        xfer(12, 32'h855, r);      // truncated data write
        repeat (200) @(negedge clk);
        chk(ngot[0] == 0, "R5 12-edge no frame", ngot[0], 0);
    endtask

    task automatic t_rx;
        logic [15:0] r;
        logic [7:0] v [5] = '{8'h11, 8'h82, 8'h5A, 8'hF0, 8'h3C};
        for (int i = 0; i < 5; i++) send_rx(0, v[i]);
        repeat (50) @(negedge clk);
        pick(2);
        cmd(16'h0000, r);
        chk(r[15] == 1'b0, "R3 ch2 sees no ch0 data", r[15], 0);
        pick(0);
        for (int i = 0; i < 4; i++) begin
            cmd(16'h0000, r);
            chk(r[15] && r[13:8] == 0 && r[7:0] == v[i], "R10 R2 fifo order", r, {8'h80, v[i]});
        end
        cmd(16'h0000, r);
        chk(r[15] == 1'b0, "R10 fifth byte dropped", r[15], 0);
        cmd(16'h0000, r);
        chk(r[15] == 1'b0, "R10 empty read no effect", r[15], 0);
    endtask

    task automatic t_drop;
        logic [15:0] r;
        pick(1);
        cmd(16'hC0C7, r);          // divisor 199
        bt[1] = 200;
        cmd(16'h803C, r);
        cmd(16'h80C3, r);
        cmd(16'h8099, r);
        cmd(16'h4000, r);
        chk(r[14] == 1'b0, "R9 holding full flag", r[14], 0);
        chk(r[13:0] == 14'hC7, "R2 config in reply", r[13:0], 'hC7);
        repeat (5000) @(negedge clk);
        chk(ngot[1] == 2, "R9 third write dropped", ngot[1], 2);
        chk(got[1][0] == 8'h3C && got[1][1] == 8'hC3, "R9 frame order", {got[1][0], got[1][1]}, 16'h3CC3);
        cmd(16'h4000, r);
        chk(r[14] == 1'b1, "R9 holding empty again", r[14], 1);
    endtask

    initial begin
        fork mon(0); mon(1); mon(2); join_none
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_tx_basic();
        t_select();
        t_bad_len();
        t_rx();
        t_drop();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule